// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block lets one core of a two-core shared-memory system build atomic read-modify-write sequences. It sits beside the core's memory request path. It watches each request the core issues and the writes the other core makes to the shared memory. A load-linked records the word it reads as a reservation. A later store-conditional may write memory only while that reservation still stands. Any intervening write to the word breaks the reservation, so the sequence either completes untouched or reports failure and can be retried.

All outputs are combinational from the current request and the stored reservation. `store_en` gates the memory write. `sc_status` is the value the core writes back into the store-conditional's data register: 1 on success, 0 on failure. The reservation lives in one valid flag and one word tag. Addresses match at word granularity, with the low `WORD_LSB` bits ignored.

Top module: `resv_monitor`

## Requirements
- R1: Reset clears the reservation, so a store-conditional that arrives before any load-linked fails (`store_en`=0, `sc_status`=0).
- R2: A load-linked (`req_op`=2'b10) records the word address it reads and marks the reservation valid. A following store-conditional (`req_op`=2'b11) to the same word, at any byte offset, gives `store_en`=1 and `sc_status`=1.
- R3: A store-conditional to a word other than the reserved one gives `store_en`=0 and `sc_status`=0. `sc_status` never takes a value other than 0 or 1.
- R4: Every store-conditional clears the reservation, whether it succeeds or fails.
- R5: A write by the other core (`snoop_wr`=1) to the reserved word clears the reservation. A write by the other core to a different word leaves it intact.
- R6: A plain store (`req_op`=2'b01) always gives `store_en`=1. When it targets the reserved word, it also clears the reservation.
- R7: When the other core writes the reserved word in the same cycle as a store-conditional to that word, the store-conditional fails.
- R8: When the other core writes the same word in the same cycle as a load-linked, no valid reservation results.
- R9: A newer load-linked replaces any older reservation, so only the most recent word can succeed.
- R10: Plain loads (`req_op`=2'b00) and cycles with `req_valid`=0 leave the reservation unchanged and give `store_en`=0 and `sc_status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present this cycle |
| req_op | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| req_addr | input | ADDR_W | Byte address of the core request |
| snoop_wr | input | 1 | Other core writes shared memory this cycle |
| snoop_addr | input | ADDR_W | Byte address of the other core's write |
| store_en | output | 1 | Memory write permitted for this request |
| sc_status | output | DATA_W | Status value for the store-conditional destination register |

## Verification
The bench builds the block with `ADDR_W`=6 and `WORD_LSB`=2, which gives a shared space of only sixteen words. With so few words, random snoop writes and plain stores land on the reserved word often. That brings reservation kills, same-cycle collisions and byte-offset aliasing within reach of a few thousand random cycles. `DATA_W` stays 32, so the bench can confirm that the upper status bits remain zero.

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WORD_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snoop_wr,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              store_en,
  output logic [DATA_W-1:0] sc_status
);
  localparam int TAG_W = ADDR_W - WORD_LSB;

  logic             resv_vld;
  logic [TAG_W-1:0] resv_tag;
  logic [TAG_W-1:0] req_tag, snoop_tag;
  logic             is_st, is_ll, is_sc;
  logic             req_hit, snoop_on_req, snoop_on_resv, sc_ok;

  assign req_tag   = req_addr[ADDR_W-1:WORD_LSB];
  assign snoop_tag = snoop_addr[ADDR_W-1:WORD_LSB];

  assign is_st = req_valid && (req_op == 2'b01);
  assign is_ll = req_valid && (req_op == 2'b10);
  assign is_sc = req_valid && (req_op == 2'b11);

  assign req_hit       = resv_vld && (req_tag == resv_tag);
  assign snoop_on_req  = snoop_wr && (snoop_tag == req_tag);
  assign snoop_on_resv = snoop_wr && resv_vld && (snoop_tag == resv_tag);

  assign sc_ok     = is_sc && req_hit && !snoop_on_req;
  assign store_en  = is_st || sc_ok;
  assign sc_status = DATA_W'(sc_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_vld <= 1'b0;
      resv_tag <= '0;
    end else if (is_ll) begin
      resv_vld <= !snoop_on_req;
      resv_tag <= req_tag;
    end else if (is_sc || (is_st && req_hit) || snoop_on_resv) begin
      resv_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WORD_LSB = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic [1:0]                 req_op,
  input logic [ADDR_W-1:0]          req_addr,
  input logic                       snoop_wr,
  input logic [ADDR_W-1:0]          snoop_addr,
  input logic                       store_en,
  input logic [DATA_W-1:0]          sc_status,
  input logic                       resv_vld,
  input logic [ADDR_W-WORD_LSB-1:0] resv_tag
);
  logic same_word;
  assign same_word = snoop_addr[ADDR_W-1:WORD_LSB] == req_addr[ADDR_W-1:WORD_LSB];

  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> !resv_vld);

  p_sc_needs_resv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11 && store_en) |->
      (resv_vld && resv_tag == req_addr[ADDR_W-1:WORD_LSB]));

  p_status_binary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |-> (sc_status <= 1 && store_en == sc_status[0]));

  p_sc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |=> !resv_vld);

  p_snoop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_wr && resv_vld && snoop_addr[ADDR_W-1:WORD_LSB] == resv_tag &&
     !(req_valid && req_op == 2'b10)) |=> !resv_vld);

  p_store_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b01) |-> store_en);

  p_collide_fails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11 && snoop_wr && same_word) |-> !store_en);

  p_ll_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b10 && snoop_wr && same_word) |=> !resv_vld);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_op == 2'b00) |-> (!store_en && sc_status == '0));
endmodule

bind resv_monitor resv_monitor_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_LSB(WORD_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .snoop_wr(snoop_wr), .snoop_addr(snoop_addr),
  .store_en(store_en), .sc_status(sc_status),
  .resv_vld(resv_vld), .resv_tag(resv_tag)
);

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic          snoop_wr = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          store_en;
  logic [DW-1:0] sc_status;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int m_vld = 0;
  int m_word = 0;

  always #4 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .DATA_W(DW), .WORD_LSB(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .snoop_wr(snoop_wr), .snoop_addr(snoop_addr),
    .store_en(store_en), .sc_status(sc_status)
  );

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // exp_ok: -1 = rely on model only, 0/1 = directed expectation of a successful conditional store
  task automatic step(string tag, int v, int op, int addr, int sw, int saddr, int exp_ok);
    int e_st, e_ok, n_vld, n_word;
    @(negedge clk);
    req_valid  = v[0];
    req_op     = op[1:0];
    req_addr   = addr[AW-1:0];
    snoop_wr   = sw[0];
    snoop_addr = saddr[AW-1:0];
    #1;
    e_ok = 0;
    if (v == 1 && op == 3 && m_vld == 1 && (addr / 4) == m_word &&
        !(sw == 1 && (saddr / 4) == (addr / 4)))
      e_ok = 1;
    e_st = (v == 1 && op == 1) ? 1 : e_ok;
    if (exp_ok >= 0) check(tag, e_ok, exp_ok, "model-vs-directed");
    check(tag, int'(store_en), e_st, "store_en");
    check(tag, int'(sc_status), e_ok, "sc_status");
    n_vld = m_vld;
    n_word = m_word;
    if (sw == 1 && (saddr / 4) == m_word) n_vld = 0;
    if (v == 1) begin
      if (op == 3) n_vld = 0;
      if (op == 1 && (addr / 4) == m_word) n_vld = 0;
      if (op == 2) begin
        n_word = addr / 4;
        n_vld = (sw == 1 && (saddr / 4) == (addr / 4)) ? 0 : 1;
      end
    end
    @(posedge clk);
    m_vld = n_vld;
    m_word = n_word;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", int'(store_en), 0, "store_en in reset");
    check("R1", int'(sc_status), 0, "sc_status in reset");
    rst_n = 1'b1;
    m_vld = 0;

    step("R1", 1, 3, 'h00, 0, 0, 0);
    step("R2", 1, 2, 'h10, 0, 0, -1);
    step("R2", 1, 3, 'h13, 0, 0, 1);
    step("R4", 1, 3, 'h10, 0, 0, 0);
    step("R3", 1, 2, 'h20, 0, 0, -1);
    step("R3", 1, 3, 'h24, 0, 0, 0);
    step("R4", 1, 3, 'h20, 0, 0, 0);
    step("R5", 1, 2, 'h08, 0, 0, -1);
    step("R5", 0, 0, 'h00, 1, 'h0C, -1);
    step("R5", 1, 3, 'h08, 0, 0, 1);
    step("R5", 1, 2, 'h08, 0, 0, -1);
    step("R5", 0, 0, 'h00, 1, 'h0A, -1);
    step("R5", 1, 3, 'h08, 0, 0, 0);
    step("R6", 1, 2, 'h30, 0, 0, -1);
    step("R6", 1, 1, 'h34, 0, 0, -1);
    step("R6", 1, 3, 'h30, 0, 0, 1);
    step("R6", 1, 2, 'h30, 0, 0, -1);
    step("R6", 1, 1, 'h31, 0, 0, -1);
    step("R6", 1, 3, 'h30, 0, 0, 0);
    step("R7", 1, 2, 'h14, 0, 0, -1);
    step("R7", 1, 3, 'h14, 1, 'h17, 0);
    step("R8", 1, 2, 'h18, 1, 'h18, -1);
    step("R8", 1, 3, 'h18, 0, 0, 0);
    step("R9", 1, 2, 'h04, 0, 0, -1);
    step("R9", 1, 2, 'h28, 0, 0, -1);
    step("R9", 1, 3, 'h04, 0, 0, 0);
    step("R9", 1, 2, 'h04, 0, 0, -1);
    step("R9", 1, 2, 'h28, 0, 0, -1);
    step("R9", 1, 3, 'h28, 0, 0, 1);
    step("R10", 1, 2, 'h2C, 0, 0, -1);
    step("R10", 1, 0, 'h2C, 0, 0, 0);
    step("R10", 0, 3, 'h2C, 0, 0, 0);
    step("R10", 1, 3, 'h2C, 0, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      int v, op, sw;
      v  = ($urandom % 4 != 0) ? 1 : 0;
      op = $urandom % 4;
      sw = ($urandom % 3 == 0) ? 1 : 0;
      step("RND", v, op, $urandom % 64, sw, $urandom % 64, -1);
    end
    finish_run();
  end
endmodule